// File: doc/BRIEF.md
# Standard-mode printer port register block

This block presents a host bus with the three registers of a standard printer port: a data latch, a status byte and a control byte. The bus is synchronous. A write or read strobe qualifies a 3-bit offset, and read data is returned one clock after the read strobe. A printer is not attached. The block plays the printer side of the busy/acknowledge handshake itself, so software that polls the status register sees a plausible sequence of transitions.

A byte reaches the outside world when software releases the strobe through a control write. The stored data byte then appears on `out_byte` together with a single-cycle `out_valid` pulse. When interrupts are enabled in the stored control byte, asserting the strobe sets a pending flag. A registered copy of that flag drives the level interrupt line, and the next status read clears it.

Top module: `prt_regs`

## Requirements
- R1: Only offsets 0 (data), 1 (status) and 2 (control) are decoded. A read of offsets 3 to 7 returns 0xFF. Writes to offset 1 and to offsets 3 to 7 change no register.
- R2: After reset the data latch is 0xFF, status is 0xD9, control is 0xCC, the pending flag is clear, and `irq` and `out_valid` are 0. Status bits: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 not-error, 0 timeout.
- R3: A control write stores the written value with bits 7:6 forced to 1. Control bits: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe. Reading offset 2 returns the stored value.
- R4: A control write with bit 2 at 0 sets status to 0xD8.
- R5: A control write with bits 2, 3 and 0 all at 1 clears status bit 7. If the stored strobe bit was 0 before that write, the stored data byte is emitted on `out_byte` with `out_valid` high for exactly the following cycle.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets the pending flag if the previously stored control has bit 4 set. `irq` equals the pending flag one cycle later.
- R7: A status read returns the current status and clears the pending flag. After the read, if status bit 7 was 0 and stored strobe is 0, one of two changes follows. If bit 6 was 1, it becomes 0. Otherwise bits 6 and 7 both become 1.
- R8: A data read returns `pin_in` when control bit 5 is 1, and otherwise returns the last byte written to offset 0.
- R9: When `wr_en` and `rd_en` are high together, only the write takes effect: `rdata` keeps its value and the read has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after `rd_en` |
| pin_in | input | 8 | External input byte returned in input direction |
| out_byte | output | 8 | Emitted data byte |
| out_valid | output | 1 | One-cycle pulse marking an emitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong status value shows up on the next read of offset 1, and because every read steps the handshake, a single error corrupts the whole following sequence of polled values. A wrong stored strobe bit shows up as a missing or extra `out_valid` pulse on the next strobe-release write. A wrong pending flag is visible on `irq` two cycles after the write or read that should have changed it. Sweeping every control byte value exposes each of these within a few operations.

// File: rtl/prt_regs.sv
module prt_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       irq
);
  logic [7:0] dataw, status, ctrl;
  logic       pend;
  logic [7:0] cv, rmux;
  logic       rd_go;

  assign cv    = wdata | 8'hC0;
  assign rd_go = rd_en & ~wr_en;

  always_comb begin
    case (addr)
      3'd0:    rmux = ctrl[5] ? pin_in : dataw;
      3'd1:    rmux = status;
      3'd2:    rmux = ctrl;
      default: rmux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataw     <= 8'hFF;
      status    <= 8'hD9;
      ctrl      <= 8'hCC;
      pend      <= 1'b0;
      irq       <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= 8'hFF;
      rdata     <= 8'hFF;
    end else begin
      out_valid <= 1'b0;
      irq       <= pend;
      if (wr_en) begin
        if (addr == 3'd0) dataw <= wdata;
        if (addr == 3'd2) begin
          if (!cv[2]) status <= 8'hD8;
          else if (cv[3]) begin
            if (cv[0]) begin
              status[7] <= 1'b0;
              if (!ctrl[0]) begin
                out_valid <= 1'b1;
                out_byte  <= dataw;
              end
            end else if (ctrl[4]) pend <= 1'b1;
          end
          ctrl <= cv;
        end
      end else if (rd_go) begin
        rdata <= rmux;
        if (addr == 3'd1) begin
          pend <= 1'b0;
          if (!status[7] && !ctrl[0]) begin
            if (status[6]) status[6] <= 1'b0;
            else begin
              status[6] <= 1'b1;
              status[7] <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module prt_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       out_valid,
  input logic       irq
);
  logic rd_ok;
  assign rd_ok = rd_en && !wr_en;

  p_unused_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && addr > 3'd2 |=> rdata == 8'hFF);

  p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && addr == 3'd2 |=> rdata[7:6] == 2'b11);

  p_emit_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wr_en && addr == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && addr == 3'd1 ##1 !wr_en |=> !irq);

  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en |=> $stable(rdata));
endmodule

bind prt_regs prt_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .out_valid(out_valid), .irq(irq)
);

// File: tb/test_prt_regs.sv
module test_prt_regs;
  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 8'h5A;
  logic [7:0] rdata, out_byte;
  logic       out_valid, irq;
  int checks = 0, failures = 0;

  logic [7:0] m_dw = 8'hFF, m_st = 8'hD9, m_ct = 8'hCC, m_rd = 8'hFF;
  logic       m_pend = 0, m_ev = 0;
  logic [7:0] m_eb = 8'hFF;

  always #2 clk = ~clk;

  prt_regs i_prt_regs (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .out_byte(out_byte), .out_valid(out_valid), .irq(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_wr(logic [2:0] a, logic [7:0] d);
    logic [7:0] v;
    v = d | 8'hC0;
    m_ev = 0;
    if (a == 0) m_dw = d;
    if (a == 2) begin
      if (!v[2]) m_st = 8'hD8;
      else if (v[3]) begin
        if (v[0]) begin
          m_st[7] = 0;
          if (!m_ct[0]) begin m_ev = 1; m_eb = m_dw; end
        end else if (m_ct[4]) m_pend = 1;
      end
      m_ct = v;
    end
  endtask

  task automatic model_rd(logic [2:0] a);
    m_ev = 0;
    case (a)
      0: m_rd = m_ct[5] ? pin_in : m_dw;
      1: m_rd = m_st;
      2: m_rd = m_ct;
      default: m_rd = 8'hFF;
    endcase
    if (a == 1) begin
      m_pend = 0;
      if (!m_st[7] && !m_ct[0]) begin
        if (m_st[6]) m_st[6] = 0;
        else begin m_st[6] = 1; m_st[7] = 1; end
      end
    end
  endtask

  task automatic op(logic w, logic r, logic [2:0] a, logic [7:0] d, string tag);
    logic old_pend;
    old_pend = m_pend;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (w) model_wr(a, d); else if (r) model_rd(a); else m_ev = 0;
    chk({tag, " rdata"}, rdata, m_rd);
    chk({tag, " R5 out_valid"}, {7'd0, out_valid}, {7'd0, m_ev});
    if (m_ev) chk({tag, " R5 out_byte"}, out_byte, m_eb);
    chk({tag, " R6 irq lag"}, {7'd0, irq}, {7'd0, old_pend});
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R5 pulse end"}, {7'd0, out_valid}, 8'd0);
    chk({tag, " R6 irq"}, {7'd0, irq}, {7'd0, m_pend});
  endtask

  initial begin
    #700000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R2 irq reset", {7'd0, irq}, 8'd0);
    chk("R2 out_valid reset", {7'd0, out_valid}, 8'd0);
    op(0, 1, 2, 0, "R2 ctrl");     chk("R2 ctrl value", rdata, 8'hCC);
    op(0, 1, 0, 0, "R2 data");     chk("R2 data value", rdata, 8'hFF);
    op(0, 1, 1, 0, "R2 status");   chk("R2 status value", rdata, 8'hD9);

    op(1, 0, 0, 8'h41, "R8 wr");
    op(1, 0, 2, 8'h0D, "R5 release");
    chk("R5 emitted byte", out_byte, 8'h41);
    op(0, 1, 1, 0, "R7 s1");       chk("R7 status 59", rdata, 8'h59);
    op(1, 0, 2, 8'h0C, "R6 assert no inten");
    op(0, 1, 1, 0, "R7 s2");       chk("R7 status 59b", rdata, 8'h59);
    op(0, 1, 1, 0, "R7 s3");       chk("R7 status 19", rdata, 8'h19);
    op(0, 1, 1, 0, "R7 s4");       chk("R7 status D9", rdata, 8'hD9);

    op(1, 0, 2, 8'h1C, "R6 en");
    op(1, 0, 2, 8'h1D, "R6 rel");
    op(1, 0, 2, 8'h1C, "R6 set");  chk("R6 irq high", {7'd0, irq}, 8'd1);
    op(0, 1, 1, 0, "R6 clear");    chk("R6 irq low", {7'd0, irq}, 8'd0);

    op(1, 0, 2, 8'h08, "R4 init");
    op(0, 1, 1, 0, "R4 rd");       chk("R4 status D8", rdata, 8'hD8);

    op(1, 0, 2, 8'h2C, "R8 dir in");
    pin_in = 8'hA7;
    op(0, 1, 0, 0, "R8 rd pin");   chk("R8 pin value", rdata, 8'hA7);

    op(1, 1, 2, 8'h0C, "R9 both"); chk("R9 rdata held", rdata, 8'hA7);

    for (int v = 0; v < 256; v++) begin
      pin_in = ~v[7:0];
      op(1, 0, 0, v[7:0], "R8 sweep wdata");
      op(1, 0, 3'(3 + v % 5), ~v[7:0], "R1 sweep ignored");
      op(1, 0, 1, ~v[7:0], "R1 sweep status wr");
      op(1, 0, 2, v[7:0], "R3 sweep ctrl");
      op(0, 1, 2, 0, "R3 sweep ctrl rd");
      op(0, 1, 1, 0, "R7 sweep status");
      op(0, 1, 0, 0, "R8 sweep data rd");
      op(0, 1, 3'(3 + v % 5), 0, "R1 sweep unused rd");
      op(1, 1, 1, 0, "R9 sweep both");
      op(0, 1, 1, 0, "R7 sweep status2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule